// File: doc/BRIEF.md
# Bit Sorter with Population Count

This block takes a bit vector of configurable width and returns a vector of the same width holding the same number of ones. In the output, all ones sit at the most significant end and all zeros fill the rest. The block computes the number of ones in the input first, and that count alone sets the output. The output is therefore a thermometer code, not a shifted or rotated copy of the input.

The count is also available on its own output port. The port is wide enough to show every value from zero up to the full width. The block is purely combinational, with no clock, no storage and no handshake. Both outputs settle after the input changes. Typical uses are occupancy summaries, threshold masks and priority fill patterns.

Top module: `bit_packer`

## Requirements
- R1: `ones_cnt` equals the number of bits set to 1 in `din`.
- R2: `packed_out` holds exactly `ones_cnt` bits set to 1.
- R3: Bit `WIDTH-1-i` of `packed_out` is 1 exactly when i < `ones_cnt`, for i from 0 to WIDTH-1. This places every 1 above every 0.
- R4: `ones_cnt` is $clog2(WIDTH+1) bits wide and never exceeds WIDTH.
- R5: An all-zero `din` gives an all-zero `packed_out` and a count of 0.
- R6: An all-ones `din` gives an all-ones `packed_out` and a count of WIDTH.
- R7: With WIDTH=8, `din` = 8'b00011001 gives `packed_out` = 8'b11100000 and a count of 3.
- R8: Both outputs depend only on the present `din`, with no clock or storage. Any input pattern gives the same result whenever it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | WIDTH | Vector to be sorted |
| ones_cnt | output | $clog2(WIDTH+1) | Number of ones in `din` |
| packed_out | output | WIDTH | Ones packed toward the MSB, zeros toward the LSB |

## Verification
The count and the sorted vector are produced from the same input at the same moment. A fault in either one shows up as a disagreement between them. The bench applies each pattern and waits one time unit. It then compares both outputs against a software model that counts the ones and builds the thermometer itself. At width 8 it applies every input pattern. A 37-bit instance gets sparse, dense and uniform random patterns, one-hot patterns and the extreme values. Patterns are repeated out of order to confirm that no earlier input leaves a trace.

// File: rtl/bit_packer.sv
module bit_packer #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]               din,
  output logic [$clog2(WIDTH+1)-1:0]     ones_cnt,
  output logic [WIDTH-1:0]               packed_out
);
  localparam int CW = $clog2(WIDTH+1);

  logic [CW-1:0] tally;

  always_comb begin
    tally = '0;
    for (int b = 0; b < WIDTH; b++)
      tally = tally + CW'(din[b]);
  end

  assign ones_cnt = tally;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_therm
      assign packed_out[WIDTH-1-k] = (CW'(k) < tally);
    end
  endgenerate

  logic [WIDTH-1:0] zero_tail;
  assign zero_tail = ~packed_out;

  always_comb begin
    p_count_r1: assert (ones_cnt == CW'($countones(din)))
      else $error("count mismatch");
    p_weight_r2: assert ($countones(packed_out) == int'(ones_cnt))
      else $error("output weight differs from count");
    p_shape_r3: assert ((zero_tail & (zero_tail + 1'b1)) == '0)
      else $error("output is not a thermometer code");
    p_bound_r4: assert (int'(ones_cnt) <= WIDTH)
      else $error("count out of range");
    p_empty_r5: assert (din != '0 || (packed_out == '0 && ones_cnt == '0))
      else $error("zero input not preserved");
    p_full_r6: assert (din != '1 || (packed_out == '1 && int'(ones_cnt) == WIDTH))
      else $error("full input not preserved");
  end
endmodule

// File: tb/bit_packer_bench.sv
module bit_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W8  = 8;
  localparam int WW  = 37;
  localparam int C8  = $clog2(W8+1);
  localparam int CWW = $clog2(WW+1);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W8-1:0]  d8;
  logic [C8-1:0]  c8;
  logic [W8-1:0]  p8;
  logic [WW-1:0]  dw;
  logic [CWW-1:0] cw;
  logic [WW-1:0]  pw;

  bit_packer #(.WIDTH(W8)) u_bit_packer (.din(d8), .ones_cnt(c8), .packed_out(p8));
  bit_packer #(.WIDTH(WW)) u_bit_packer_w (.din(dw), .ones_cnt(cw), .packed_out(pw));

  function automatic int ref_count(input logic [63:0] v, input int w);
    int n = 0;
    for (int i = 0; i < w; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [63:0] ref_therm(input int n, input int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[w-1-i] = (i < n);
    return r;
  endfunction

  task automatic apply8(input logic [W8-1:0] v, input string req);
    int n;
    logic [63:0] e;
    d8 = v;
    #1;
    n = ref_count({56'd0, v}, W8);
    e = ref_therm(n, W8);
    checks++;
    if (int'(c8) != n || p8 != e[W8-1:0]) begin
      fails++;
      $display("FAIL %s w8 din=%b: count=%0d out=%b expected count=%0d out=%b",
               req, v, c8, p8, n, e[W8-1:0]);
    end
  endtask

  task automatic applyw(input logic [WW-1:0] v, input string req);
    int n;
    logic [63:0] e;
    dw = v;
    #1;
    n = ref_count({27'd0, v}, WW);
    e = ref_therm(n, WW);
    checks++;
    if (int'(cw) != n || pw != e[WW-1:0]) begin
      fails++;
      $display("FAIL %s w37 din=%h: count=%0d out=%h expected count=%0d out=%h",
               req, v, cw, pw, n, e[WW-1:0]);
    end
  endtask

  task automatic t_zero;
    apply8('0, "R5");
    applyw('0, "R5");
    checks++;
    if (c8 != '0 || p8 != '0) begin
      fails++;
      $display("FAIL R5 zero: count=%0d out=%b expected 0 00000000", c8, p8);
    end
  endtask

  task automatic t_full;
    apply8('1, "R6");
    applyw('1, "R6");
    checks++;
    if (int'(cw) != WW || pw != '1) begin
      fails++;
      $display("FAIL R6 full: count=%0d out=%h expected %0d all-ones", cw, pw, WW);
    end
  endtask

  task automatic t_example;
    d8 = 8'b00011001;
    #1;
    checks++;
    if (p8 != 8'b11100000 || c8 != 4'd3) begin
      fails++;
      $display("FAIL R7 example: out=%b count=%0d expected 11100000 3", p8, c8);
    end
  endtask

  task automatic t_width;
    checks++;
    if ($bits(c8) != 4 || $bits(cw) != 6) begin
      fails++;
      $display("FAIL R4 width: %0d/%0d expected 4/6", $bits(c8), $bits(cw));
    end
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < 256; v++) apply8(W8'(v), "R1 R2 R3");
  endtask

  task automatic t_onehot;
    for (int i = 0; i < WW; i++) applyw(WW'(1) << i, "R3");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      applyw(a[WW-1:0], "R1");
      applyw(a[WW-1:0] & b[WW-1:0], "R2");
      applyw(a[WW-1:0] | b[WW-1:0], "R3");
    end
  endtask

  task automatic t_history;
    apply8(8'hFF, "R8");
    apply8(8'h01, "R8");
    apply8(8'h00, "R8");
    apply8(8'h01, "R8");
    applyw('1, "R8");
    applyw(WW'(5), "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    d8 = '0;
    dw = '0;
    @(negedge clk);
    t_zero;
    t_full;
    t_example;
    t_width;
    t_exhaustive;
    t_onehot;
    t_random;
    t_history;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule